// File: doc/BRIEF.md
# Flash In-System Programming Command Controller

This block lets a processor reprogram an on-chip, word-organised flash through a small set of registers. Software loads a target byte address, a data word and a 6-bit command, then writes the start bit. The controller holds the operation for a fixed number of cycles and then carries it out against a behavioural flash array. The operation is one of: read a word, program a word, erase a page, return an identification word, or move the vector page.

The array is split into three regions: application, loader and configuration. Each region has its own update-enable bit. The controller checks every operation against those permissions and against the address range and word alignment before it acts. A rejected operation changes nothing except a sticky fail flag, which software clears by writing one to it.

The processor's fetch path passes through the block. Byte addresses below 0x200 are redirected to a 512-byte window chosen by the remap command. Two values sampled while reset is asserted are read back through the registers: the boot-selection configuration field and the data-region base.

Top module: `isp_ctrl`

## Requirements
- R1: While reset is asserted, the block clears every writable register and captures `cfg_boot` and `cfg_dfbase`. After reset:
  - control (0x00) reads back with only bit 1 set, to the inverse of `cfg_boot[0]`;
  - status (0x40) holds the captured `cfg_boot` in bits [2:1];
  - base (0x14) holds the captured `cfg_dfbase`;
  - the flash array is all ones.
- R2: Writing 1 to bit 0 of trigger (0x10) while idle and enabled starts an operation. Trigger bit 0 and status bit 0 then read 1 for exactly OP_CYCLES cycles and return to 0 when the operation completes.
- R3: If control bit 0 (enable) is 0, a trigger write starts nothing. The trigger bit stays 0 and the data register (0x08) is unchanged.
- R4: A trigger write while an operation is running is ignored. The running operation still ends OP_CYCLES cycles after its own start.
- R5: Command 0x00 copies the addressed flash word into the data register on completion.
- R6: Command 0x21 replaces the addressed word with its bitwise AND with the data register, so it can only clear bits.
- R7: Command 0x22 sets every word of the page containing the address (PAGE_WORDS words, 64 bytes by default) to all ones. Other pages are untouched.
- R8: Command 0x04 loads UID_WORD into the data register. Command 0x0B loads 0x000000DA.
- R9: A program or erase fails in each of these cases, leaving flash and the data register unchanged and still clearing the trigger bit:
  - it targets the application region (bytes 0x000–0x3FF by default) while control bit 3 is 0;
  - it targets the loader region (0x400–0x4FF) while control bit 5 is 0;
  - it targets the configuration region (0x500–0x53F) while control bit 4 is 0.
- R10: An address with bits [1:0] not equal to 00, or at or beyond the end of flash (0x540), fails every read, program, erase and remap command.
- R11: The fail flag reads at control bit 6 and status bit 6. It is cleared only by writing 1 to bit 6 of either register. Writing 0 to bit 6 has no effect.
- R12: Command 0x2E loads address bits [20:9] into status bits [20:9]. Fetch byte addresses below 0x200 then read flash at {status[20:9], addr[8:0]}. Other fetch addresses are used unchanged. Any fetch outside flash returns 0. Fetch data appears one cycle after the address.
- R13: Control bits 0, 1, 3, 4 and 5 read back as written, and bit 2 reads 0. Access-time register (0x18) keeps only bits 4 and 6.
- R14: Any command code other than the six listed fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_boot | input | 2 | Boot-selection configuration field, sampled in reset |
| cfg_dfbase | input | 32 | Data-region base from configuration, sampled in reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read enable |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Register read data, combinational, 0 when not enabled |
| fetch_addr | input | 32 | Processor fetch byte address |
| fetch_data | output | 32 | Fetched word, registered |

## Verification
The hardest condition to reach from the ports is a second start request landing while an operation is still counting down. The bench fires a trigger write from inside its busy-cycle counting loop, two cycles into a running operation. It then confirms that the busy time still equals OP_CYCLES.

Rejected operations are also delicate, because they must leave no trace. Before each failing command the bench programs or erases nearby words and loads a distinct data word. Afterwards it reads the words and the data register back through ordinary read commands, clearing the flag in between.

// File: rtl/isp_pkg.sv
// Package: shared command codes and register offsets for the flash ISP controller.
// Assumes byte-addressed registers on an 8-bit offset bus.
package isp_pkg;

    typedef enum logic [5:0] {
        CMD_READ  = 6'h00,
        CMD_UID   = 6'h04,
        CMD_MAKER = 6'h0B,
        CMD_PROG  = 6'h21,
        CMD_ERASE = 6'h22,
        CMD_REMAP = 6'h2E
    } isp_cmd_e;

    localparam logic [7:0] OFF_CTL  = 8'h00;
    localparam logic [7:0] OFF_ADR  = 8'h04;
    localparam logic [7:0] OFF_DAT  = 8'h08;
    localparam logic [7:0] OFF_CMD  = 8'h0C;
    localparam logic [7:0] OFF_TRG  = 8'h10;
    localparam logic [7:0] OFF_BASE = 8'h14;
    localparam logic [7:0] OFF_ACC  = 8'h18;
    localparam logic [7:0] OFF_STAT = 8'h40;

    localparam logic [31:0] MAKER_WORD = 32'h0000_00DA;

endpackage

// File: rtl/isp_guard.sv
// Module: legality check for one ISP operation.
// Decides from command, byte address and the three region update enables whether
// the operation must be rejected. Regions are laid out application, loader, config.
module isp_guard
    import isp_pkg::*;
#(
    parameter int APP_WORDS = 256,
    parameter int LDR_WORDS = 64,
    parameter int CFG_WORDS = 16
) (
    input  logic [5:0]  cmd,
    input  logic [31:0] addr,
    input  logic        app_en,
    input  logic        ldr_en,
    input  logic        cfg_en,
    output logic        fail
);
    localparam logic [31:0] APP_END = 32'(APP_WORDS * 4);
    localparam logic [31:0] LDR_END = 32'(APP_WORDS * 4 + LDR_WORDS * 4);
    localparam logic [31:0] ALL_END = 32'((APP_WORDS + LDR_WORDS + CFG_WORDS) * 4);

    logic bad_addr;
    logic locked;

    // Address shape and region lock evaluation.
    always_comb begin
        bad_addr = (addr[1:0] != 2'b00) || (addr >= ALL_END);
        if (addr < APP_END)      locked = !app_en;
        else if (addr < LDR_END) locked = !ldr_en;
        else                     locked = !cfg_en;
    end

    // Per-command rejection decision.
    always_comb begin
        case (cmd)
            CMD_READ, CMD_REMAP: fail = bad_addr;
            CMD_UID, CMD_MAKER:  fail = 1'b0;
            CMD_PROG, CMD_ERASE: fail = bad_addr || locked;
            default:             fail = 1'b1;
        endcase
    end
endmodule

// File: rtl/isp_flash_array.sv
// Module: behavioural word flash with one program port, one page-erase port and
// two combinational read ports. Program clears bits only (AND); erase sets a page
// to all ones. Reset models a freshly erased array. Indices must be in range.
module isp_flash_array #(
    parameter int WORDS      = 336,
    parameter int PAGE_WORDS = 16,
    parameter int IDX_W      = $clog2(WORDS),
    parameter int PG_SH      = $clog2(PAGE_WORDS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   prg_en,
    input  logic [IDX_W-1:0]       prg_idx,
    input  logic [31:0]            prg_data,
    input  logic                   ers_en,
    input  logic [IDX_W-PG_SH-1:0] ers_page,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [31:0]            rd_word,
    input  logic [IDX_W-1:0]       fch_idx,
    output logic [31:0]            fch_word
);
    logic [31:0] mem [WORDS];

    // Cell update: erase state on reset, page erase, or bit-clearing program.
    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (!rst_n)
                mem[i] <= '1;
            else if (ers_en && ((i >> PG_SH) == int'(ers_page)))
                mem[i] <= '1;
            else if (prg_en && (i == int'(prg_idx)))
                mem[i] <= mem[i] & prg_data;
        end
    end

    // Combinational read ports.
    always_comb begin
        rd_word  = (int'(rd_idx)  < WORDS) ? mem[rd_idx]  : '0;
        fch_word = (int'(fch_idx) < WORDS) ? mem[fch_idx] : '0;
    end
endmodule

// File: rtl/isp_ctrl.sv
// Module: flash ISP command controller (top).
// Register file, start/countdown sequencer, completion actions and vector-page
// fetch redirection. Assumes one register write per cycle and a fixed
// OP_CYCLES-cycle operation latency; operands are latched at start.
module isp_ctrl
    import isp_pkg::*;
#(
    parameter int          APP_WORDS  = 256,
    parameter int          LDR_WORDS  = 64,
    parameter int          CFG_WORDS  = 16,
    parameter int          PAGE_WORDS = 16,
    parameter int          OP_CYCLES  = 4,
    parameter logic [31:0] UID_WORD   = 32'h5A17_C0DE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cfg_boot,
    input  logic [31:0] cfg_dfbase,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    input  logic [7:0]  rd_addr,
    output logic [31:0] rd_data,
    input  logic [31:0] fetch_addr,
    output logic [31:0] fetch_data
);
    localparam int          WORDS   = APP_WORDS + LDR_WORDS + CFG_WORDS;
    localparam int          IDX_W   = $clog2(WORDS);
    localparam int          PG_SH   = $clog2(PAGE_WORDS);
    localparam int          CNT_W   = $clog2(OP_CYCLES + 1);
    localparam logic [31:0] ALL_END = 32'(WORDS * 4);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(OP_CYCLES - 1);

    logic        isp_en_q, bs_q, app_en_q, cfg_en_q, ldr_en_q, ff_q;
    logic [31:0] addr_q, data_q, dfbase_q, fetch_q;
    logic [5:0]  cmd_q, op_cmd_q;
    logic [31:0] op_addr_q;
    logic        go_q, op_fail_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]  acc_q, cbs_q;
    logic [11:0] vecmap_q;

    logic        start, done, ok_done, guard_fail;
    logic [31:0] fch_phys, rd_word, fch_word;
    logic [IDX_W-1:0] op_idx;

    isp_guard #(
        .APP_WORDS(APP_WORDS), .LDR_WORDS(LDR_WORDS), .CFG_WORDS(CFG_WORDS)
    ) u_guard (
        .cmd(cmd_q), .addr(addr_q), .app_en(app_en_q), .ldr_en(ldr_en_q),
        .cfg_en(cfg_en_q), .fail(guard_fail)
    );

    // Sequencer control strobes.
    always_comb begin
        start   = wr_en && (wr_addr == OFF_TRG) && wr_data[0] && !go_q && isp_en_q;
        done    = go_q && (cnt_q == '0);
        ok_done = done && !op_fail_q;
        op_idx  = op_addr_q[IDX_W+1:2];
        fch_phys = (fetch_addr < 32'h200) ? {11'b0, vecmap_q, fetch_addr[8:0]} : fetch_addr;
    end

    isp_flash_array #(.WORDS(WORDS), .PAGE_WORDS(PAGE_WORDS)) u_flash (
        .clk(clk), .rst_n(rst_n),
        .prg_en(ok_done && (op_cmd_q == CMD_PROG)), .prg_idx(op_idx), .prg_data(data_q),
        .ers_en(ok_done && (op_cmd_q == CMD_ERASE)), .ers_page(op_idx[IDX_W-1:PG_SH]),
        .rd_idx(op_idx), .rd_word(rd_word),
        .fch_idx(fch_phys[IDX_W+1:2]), .fch_word(fch_word)
    );

    // Control, access-time and configuration snapshot registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isp_en_q <= 1'b0; app_en_q <= 1'b0; cfg_en_q <= 1'b0; ldr_en_q <= 1'b0;
            bs_q     <= ~cfg_boot[0];
            cbs_q    <= cfg_boot;
            dfbase_q <= cfg_dfbase;
            acc_q    <= 2'b00;
        end else if (wr_en && wr_addr == OFF_CTL) begin
            isp_en_q <= wr_data[0]; bs_q <= wr_data[1]; app_en_q <= wr_data[3];
            cfg_en_q <= wr_data[4]; ldr_en_q <= wr_data[5];
        end else if (wr_en && wr_addr == OFF_ACC) begin
            acc_q <= {wr_data[6], wr_data[4]};
        end
    end

    // Operand registers: address and command from software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0; cmd_q <= '0;
        end else if (wr_en && wr_addr == OFF_ADR) begin
            addr_q <= wr_data;
        end else if (wr_en && wr_addr == OFF_CMD) begin
            cmd_q <= wr_data[5:0];
        end
    end

    // Start latch and countdown of the running operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q <= 1'b0; cnt_q <= '0; op_cmd_q <= '0; op_addr_q <= '0; op_fail_q <= 1'b0;
        end else if (start) begin
            go_q <= 1'b1; cnt_q <= CNT_LOAD;
            op_cmd_q <= cmd_q; op_addr_q <= addr_q; op_fail_q <= guard_fail;
        end else if (done) begin
            go_q <= 1'b0;
        end else if (go_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Data register: completion result has priority over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (ok_done && op_cmd_q == CMD_READ)
            data_q <= rd_word;
        else if (ok_done && op_cmd_q == CMD_UID)
            data_q <= UID_WORD;
        else if (ok_done && op_cmd_q == CMD_MAKER)
            data_q <= MAKER_WORD;
        else if (wr_en && wr_addr == OFF_DAT)
            data_q <= wr_data;
    end

    // Sticky fail flag: set on a rejected completion, write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ff_q <= 1'b0;
        else if (done && op_fail_q)
            ff_q <= 1'b1;
        else if (wr_en && (wr_addr == OFF_CTL || wr_addr == OFF_STAT) && wr_data[6])
            ff_q <= 1'b0;
    end

    // Vector page select and registered fetch path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vecmap_q <= '0; fetch_q <= '0;
        end else begin
            if (ok_done && op_cmd_q == CMD_REMAP) vecmap_q <= op_addr_q[20:9];
            fetch_q <= (fch_phys < ALL_END) ? fch_word : '0;
        end
    end

    assign fetch_data = fetch_q;

    // Register read multiplexer.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (rd_addr)
                OFF_CTL:  rd_data = {25'b0, ff_q, ldr_en_q, cfg_en_q, app_en_q, 1'b0, bs_q, isp_en_q};
                OFF_ADR:  rd_data = addr_q;
                OFF_DAT:  rd_data = data_q;
                OFF_CMD:  rd_data = {26'b0, cmd_q};
                OFF_TRG:  rd_data = {31'b0, go_q};
                OFF_BASE: rd_data = dfbase_q;
                OFF_ACC:  rd_data = {25'b0, acc_q[1], 1'b0, acc_q[0], 4'b0};
                OFF_STAT: rd_data = {11'b0, vecmap_q, 2'b0, ff_q, 3'b0, cbs_q, go_q};
                default:  rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/isp_ctrl_chk.sv
// Module: protocol checker for isp_ctrl, attached by bind below.
// Assumes the register offsets of isp_pkg; busy length checked with a counter.
module isp_ctrl_chk #(
    parameter int OP_CYCLES = 4,
    parameter int CNT_W     = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [7:0]       wr_addr,
    input logic [31:0]      wr_data,
    input logic             go_q,
    input logic             ff_q,
    input logic             isp_en_q,
    input logic [CNT_W-1:0] cnt_q
);
    logic [CNT_W:0] run_q;

    // Count consecutive busy cycles already elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (go_q) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go_q |-> (int'(run_q) < OP_CYCLES));

    p_no_start_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 8'h10 && wr_data[0] && !go_q && !isp_en_q) |=> !go_q);

    p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go_q && cnt_q != '0) |=> (go_q && cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

    p_fail_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ff_q) |-> ($past(go_q) && !go_q));

    p_fail_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ff_q && !(wr_en && (wr_addr == 8'h00 || wr_addr == 8'h40) && wr_data[6])) |=> ff_q);
endmodule

bind isp_ctrl isp_ctrl_chk #(.OP_CYCLES(OP_CYCLES), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .go_q(go_q), .ff_q(ff_q), .isp_en_q(isp_en_q), .cnt_q(cnt_q)
);

// File: tb/isp_ctrl_tb_top.sv
`timescale 1ns/1ps
// Directed bench for isp_ctrl: one task per scenario, each checking its own results.
module isp_ctrl_tb_top;
    localparam int OPC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_boot = 2'b10;
    logic [31:0] cfg_dfbase = 32'h0000_0500;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] fetch_addr = '0;
    logic [31:0] fetch_data;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    isp_ctrl #(.OP_CYCLES(OPC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_boot(cfg_boot), .cfg_dfbase(cfg_dfbase),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .fetch_addr(fetch_addr), .fetch_data(fetch_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 v = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic fetch(input logic [31:0] a, output logic [31:0] v);
        @(negedge clk);
        fetch_addr = a;
        @(negedge clk);
        v = fetch_data;
    endtask

    task automatic run_op(input logic [5:0] c, input logic [31:0] a, input logic [31:0] d);
        logic [31:0] s;
        wr(8'h04, a); wr(8'h08, d); wr(8'h0C, {26'b0, c}); wr(8'h10, 32'h1);
        for (int i = 0; i < 50; i++) begin
            rd(8'h40, s);
            if (!s[0]) break;
        end
    endtask

    task automatic read_word(input logic [31:0] a, output logic [31:0] v);
        run_op(6'h00, a, 32'h0);
        rd(8'h08, v);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h00, v); chk("R1 control after reset", v, 32'h2);
        rd(8'h40, v); chk("R1 status after reset", v, 32'h4);
        rd(8'h14, v); chk("R1 base capture", v, 32'h0000_0500);
        rd(8'h08, v); chk("R1 data after reset", v, 32'h0);
        fetch(32'h0, v); chk("R1 flash erased", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(8'h00, 32'h3F); rd(8'h00, v); chk("R13 control readback", v, 32'h3B);
        wr(8'h18, 32'hFF); rd(8'h18, v); chk("R13 access-time bits", v, 32'h50);
    endtask

    task automatic t_timing;
        logic [31:0] v;
        int n;
        wr(8'h04, 32'h0); wr(8'h0C, 32'h0); wr(8'h10, 32'h1);
        n = 0;
        forever begin
            rd_en = 1'b1; rd_addr = 8'h10; #1 v = rd_data; rd_en = 1'b0;
            if (!v[0] || n > 20) break;
            n++;
            @(negedge clk);
        end
        chk("R2 busy length", 32'(n), 32'(OPC));
        wr(8'h10, 32'h1);
        n = 0;
        forever begin
            rd_en = 1'b1; rd_addr = 8'h40; #1 v = rd_data; rd_en = 1'b0;
            if (!v[0] || n > 20) break;
            n++;
            if (n == 2) begin wr_en = 1'b1; wr_addr = 8'h10; wr_data = 32'h1; end
            else wr_en = 1'b0;
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk("R4 retrigger ignored, busy length", 32'(n), 32'(OPC));
    endtask

    task automatic t_disabled;
        logic [31:0] v;
        wr(8'h00, 32'h3A);
        wr(8'h08, 32'h77); wr(8'h0C, 32'h0B); wr(8'h10, 32'h1);
        rd(8'h10, v); chk("R3 trigger stays 0", v, 32'h0);
        repeat (OPC + 2) @(negedge clk);
        rd(8'h08, v); chk("R3 data unchanged", v, 32'h77);
        wr(8'h00, 32'h3B);
    endtask

    task automatic t_prog_read;
        logic [31:0] v;
        run_op(6'h21, 32'h100, 32'h1234_5678);
        read_word(32'h100, v); chk("R5 R6 first program", v, 32'h1234_5678);
        run_op(6'h21, 32'h100, 32'hF0F0_F0F0);
        read_word(32'h100, v); chk("R6 program ANDs", v, 32'h1030_5070);
    endtask

    task automatic t_erase;
        logic [31:0] v;
        run_op(6'h21, 32'h13C, 32'h0);
        run_op(6'h21, 32'h140, 32'h0);
        run_op(6'h22, 32'h108, 32'h0);
        read_word(32'h100, v); chk("R7 page first word", v, 32'hFFFF_FFFF);
        read_word(32'h13C, v); chk("R7 page last word", v, 32'hFFFF_FFFF);
        read_word(32'h140, v); chk("R7 next page kept", v, 32'h0);
    endtask

    task automatic t_ids;
        logic [31:0] v;
        run_op(6'h04, 32'h0, 32'h0); rd(8'h08, v); chk("R8 unique id", v, 32'h5A17_C0DE);
        run_op(6'h0B, 32'h0, 32'h0); rd(8'h08, v); chk("R8 maker id", v, 32'hDA);
    endtask

    task automatic t_perm;
        logic [31:0] v;
        wr(8'h00, 32'h33);
        run_op(6'h22, 32'h140, 32'h0);
        rd(8'h00, v); chk("R9 app locked flag", v, 32'h73);
        rd(8'h10, v); chk("R9 trigger cleared", v, 32'h0);
        wr(8'h00, 32'h73); rd(8'h00, v); chk("R11 clear via control", v, 32'h33);
        read_word(32'h140, v); chk("R9 app word untouched", v, 32'h0);
        wr(8'h00, 32'h1B);
        run_op(6'h21, 32'h400, 32'h0);
        rd(8'h40, v); chk("R9 loader locked flag", v[6], 32'h1);
        wr(8'h40, 32'h40);
        read_word(32'h400, v); chk("R9 loader word untouched", v, 32'hFFFF_FFFF);
        wr(8'h00, 32'h3B);
        run_op(6'h21, 32'h400, 32'h0);
        read_word(32'h400, v); chk("R9 loader unlocked program", v, 32'h0);
        wr(8'h00, 32'h2B);
        run_op(6'h21, 32'h500, 32'h0);
        rd(8'h40, v); chk("R9 config locked flag", v[6], 32'h1);
        wr(8'h40, 32'h40); wr(8'h00, 32'h3B);
        read_word(32'h500, v); chk("R9 config word untouched", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_addr;
        logic [31:0] v;
        run_op(6'h00, 32'h102, 32'h1111_2222);
        rd(8'h08, v); chk("R10 misaligned keeps data", v, 32'h1111_2222);
        rd(8'h40, v); chk("R10 misaligned flag", v[6], 32'h1);
        wr(8'h40, 32'h0); rd(8'h40, v); chk("R11 write 0 keeps flag", v[6], 32'h1);
        wr(8'h00, 32'h3B); rd(8'h00, v); chk("R11 control bit6=0 keeps flag", v, 32'h7B);
        wr(8'h40, 32'h40); rd(8'h40, v); chk("R11 clear via status", v[6], 32'h0);
        run_op(6'h00, 32'h540, 32'h3333_4444);
        rd(8'h08, v); chk("R10 out of range keeps data", v, 32'h3333_4444);
        rd(8'h40, v); chk("R10 out of range flag", v[6], 32'h1);
        wr(8'h40, 32'h40);
        read_word(32'h53C, v); chk("R10 last word legal", v, 32'hFFFF_FFFF);
        rd(8'h40, v); chk("R10 last word no flag", v[6], 32'h0);
    endtask

    task automatic t_badcmd;
        logic [31:0] v;
        run_op(6'h3F, 32'h0, 32'h0);
        rd(8'h40, v); chk("R14 unknown command flag", v[6], 32'h1);
        wr(8'h40, 32'h40);
    endtask

    task automatic t_remap;
        logic [31:0] v;
        run_op(6'h21, 32'h204, 32'hCAFE_0000);
        run_op(6'h2E, 32'h200, 32'h0);
        rd(8'h40, v); chk("R12 vector field", v, 32'h204);
        fetch(32'h004, v); chk("R12 remapped fetch", v, 32'hCAFE_0000);
        fetch(32'h204, v); chk("R12 direct fetch", v, 32'hCAFE_0000);
        fetch(32'h100, v); chk("R12 remapped other word", v, 32'hFFFF_FFFF);
        fetch(32'h600, v); chk("R12 out of range fetch", v, 32'h0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_timing();
        t_disabled();
        t_prog_read();
        t_erase();
        t_ids();
        t_perm();
        t_addr();
        t_badcmd();
        t_remap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule